// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter

This block answers a processor's interrupt acknowledge cycle on behalf of a set of request sources. Each source presents a request bit, a 3-bit priority level, a 4-bit arbitration number, a vector number and a flag that says whether it wants an autovector. When an acknowledge cycle starts, the block latches the level being acknowledged. Only sources whose level matches that level and whose arbitration number is nonzero take part in contention, and the highest arbitration number wins.

The winner ends the cycle in one of two ways. It can supply its own vector with a data-acknowledge pulse, or it can ask for an autovector, which is formed from a fixed base plus the level. An external autovector input, which may be tied active, forces the autovector response. If nothing answers within a set number of cycles, a bus monitor raises a bus error and the spurious vector is used. In every case the block turns the vector number into a word-aligned vector address and reports the level it acknowledged.

Top module: `iack_arbiter`

## Requirements
- R1: After reset, `done`, `dsack`, `avec` and `berr` are 0, and `vec_num`, `vec_addr` and `ipl` are 0.
- R2: A source contends only when its `src_req` bit is 1, its level equals the latched acknowledge level and its arbitration number is nonzero. Source i uses bits [3i+2:3i] of `src_level`, [4i+3:4i] of `src_arb` and [8i+7:8i] of `src_vec`.
- R3: Among the contenders, the source with the highest arbitration number wins.
- R4: A winner whose `src_auto` bit is 0 ends the cycle with `dsack` = 1 and `vec_num` equal to its own vector. `done` rises one cycle after the clock edge that samples `ack_start`.
- R5: A winner whose `src_auto` bit is 1 ends the cycle with `avec` = 1 and `vec_num` = AUTOVEC_BASE (0x30) + level, also one cycle after the start.
- R6: While a cycle is in progress, `avec_pin` = 1 forces the autovector response and takes precedence over any winner.
- R7: If there is no contender and `avec_pin` = 0, `berr` = 1 and `vec_num` = SPUR_VEC (0x0F). `done` rises TIMEOUT (12) cycles after the start.
- R8: `vec_addr` equals `vec_num` shifted left by one bit.
- R9: `ipl` holds the level that was latched when the cycle started.
- R10: `done` is a one-cycle pulse. Exactly one of `dsack`, `avec` and `berr` is 1 while `done` is 1, and none of them is 1 at any other time.
- R11: An `ack_start` that arrives while a cycle is in progress is ignored. It changes neither the latched level nor the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_start | input | 1 | Pulse that begins an acknowledge cycle |
| ack_level | input | 3 | Level being acknowledged (address bits 3:1) |
| src_req | input | N_SRC | Request bit for each source |
| src_level | input | N_SRC*3 | Priority level for each source |
| src_arb | input | N_SRC*4 | Arbitration number for each source |
| src_vec | input | N_SRC*8 | Vector supplied by each source |
| src_auto | input | N_SRC | Source wants an autovector |
| avec_pin | input | 1 | External autovector request |
| done | output | 1 | Cycle finished (one-cycle pulse) |
| dsack | output | 1 | Vector supplied by the winner |
| avec | output | 1 | Autovector response |
| berr | output | 1 | Bus error, spurious vector used |
| vec_num | output | 8 | Resulting vector number |
| vec_addr | output | 9 | Vector address (vector number times 2) |
| ipl | output | 3 | Latched priority level |

## Verification
Each input pattern is aimed at one question. A single matching source placed beside a higher-numbered source at another level shows that the level filter works. Several sources at one level, one of them with arbitration number zero and a stronger one at a different level, show that the highest number wins. An autovector-flagged winner and the external pin separate the two autovector paths from the supplied-vector path. A level mismatch, a zero arbitration number, and a second start during the timeout window all show that the bus monitor alone ends the cycle, after the full count and with the original level.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {
    RESP_NONE   = 2'd0,
    RESP_VECTOR = 2'd1,
    RESP_AUTO   = 2'd2,
    RESP_SPUR   = 2'd3
  } resp_t;
endpackage

// File: rtl/iack_contend.sv
// Level match and arbitration-number contention among sources.
module iack_contend #(
  parameter int N_SRC = 4,
  parameter int LVL_W = 3,
  parameter int ARB_W = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] level,
  input  logic [N_SRC*ARB_W-1:0] arb,
  input  logic [LVL_W-1:0]       lvl_ack,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx
);
  logic [N_SRC-1:0] match;

  for (genvar g = 0; g < N_SRC; g++) begin : g_match
    assign match[g] = req[g]
                    && (level[g*LVL_W +: LVL_W] == lvl_ack)
                    && (arb[g*ARB_W +: ARB_W] != '0);
  end

  logic [ARB_W-1:0] best;
  always_comb begin
    best    = '0;
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (match[i] && (arb[i*ARB_W +: ARB_W] > best)) begin
        best    = arb[i*ARB_W +: ARB_W];
        win_idx = IDX_W'(i);
      end
    end
  end

  assign win_valid = |match;
endmodule

// File: rtl/iack_busmon.sv
// Counts cycles of an acknowledge cycle; flags the last allowed cycle.
module iack_busmon #(
  parameter int TIMEOUT = 12,
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  output logic expired
);
  logic             running;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (clear) begin
      running <= 1'b0;
    end else if (running && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = running && (cnt == CNT_W'(TIMEOUT - 1));
endmodule

// File: rtl/iack_vecgen.sv
// Forms the vector number for the chosen response and its word address.
module iack_vecgen
  import iack_pkg::*;
#(
  parameter int              LVL_W        = 3,
  parameter int              VEC_W        = 8,
  parameter logic [VEC_W-1:0] AUTOVEC_BASE = 8'h30,
  parameter logic [VEC_W-1:0] SPUR_VEC     = 8'h0F
) (
  input  resp_t            kind,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VEC_W-1:0] sup_vec,
  output logic [VEC_W-1:0] vec,
  output logic [VEC_W:0]   addr
);
  always_comb begin
    case (kind)
      RESP_VECTOR: vec = sup_vec;
      RESP_AUTO:   vec = AUTOVEC_BASE + VEC_W'(lvl);
      RESP_SPUR:   vec = SPUR_VEC;
      default:     vec = '0;
    endcase
  end

  assign addr = {vec, 1'b0};
endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter
  import iack_pkg::*;
#(
  parameter int               N_SRC        = 4,
  parameter int               LVL_W        = 3,
  parameter int               ARB_W        = 4,
  parameter int               VEC_W        = 8,
  parameter int               TIMEOUT      = 12,
  parameter logic [VEC_W-1:0] AUTOVEC_BASE = 8'h30,
  parameter logic [VEC_W-1:0] SPUR_VEC     = 8'h0F,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ack_start,
  input  logic [LVL_W-1:0]       ack_level,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC*LVL_W-1:0] src_level,
  input  logic [N_SRC*ARB_W-1:0] src_arb,
  input  logic [N_SRC*VEC_W-1:0] src_vec,
  input  logic [N_SRC-1:0]       src_auto,
  input  logic                   avec_pin,
  output logic                   done,
  output logic                   dsack,
  output logic                   avec,
  output logic                   berr,
  output logic [VEC_W-1:0]       vec_num,
  output logic [VEC_W:0]         vec_addr,
  output logic [LVL_W-1:0]       ipl
);
  logic             busy;
  logic [LVL_W-1:0] lvl_q;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic             expired;
  logic             accept;
  logic             fire;
  resp_t            kind;
  logic [VEC_W-1:0] vec_c;
  logic [VEC_W:0]   addr_c;

  assign accept = ack_start && !busy;

  iack_contend #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ARB_W(ARB_W)) u_contend (
    .req(src_req), .level(src_level), .arb(src_arb), .lvl_ack(lvl_q),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  iack_busmon #(.TIMEOUT(TIMEOUT)) u_busmon (
    .clk(clk), .rst(rst), .start(accept), .clear(fire), .expired(expired)
  );

  always_comb begin
    kind = RESP_NONE;
    if (busy) begin
      if (avec_pin)       kind = RESP_AUTO;
      else if (win_valid) kind = src_auto[win_idx] ? RESP_AUTO : RESP_VECTOR;
      else if (expired)   kind = RESP_SPUR;
    end
  end

  assign fire = (kind != RESP_NONE);

  iack_vecgen #(.LVL_W(LVL_W), .VEC_W(VEC_W), .AUTOVEC_BASE(AUTOVEC_BASE),
                .SPUR_VEC(SPUR_VEC)) u_vecgen (
    .kind(kind), .lvl(lvl_q), .sup_vec(src_vec[win_idx*VEC_W +: VEC_W]),
    .vec(vec_c), .addr(addr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      lvl_q    <= '0;
      done     <= 1'b0;
      dsack    <= 1'b0;
      avec     <= 1'b0;
      berr     <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
      ipl      <= '0;
    end else begin
      done  <= fire;
      dsack <= (kind == RESP_VECTOR);
      avec  <= (kind == RESP_AUTO);
      berr  <= (kind == RESP_SPUR);
      if (accept) begin
        busy  <= 1'b1;
        lvl_q <= ack_level;
      end else if (fire) begin
        busy <= 1'b0;
      end
      if (fire) begin
        vec_num  <= vec_c;
        vec_addr <= addr_c;
        ipl      <= lvl_q;
      end
    end
  end
endmodule

// File: rtl/iack_arbiter_chk.sv
module iack_arbiter_chk #(
  parameter int               LVL_W        = 3,
  parameter int               VEC_W        = 8,
  parameter int               TIMEOUT      = 12,
  parameter logic [VEC_W-1:0] AUTOVEC_BASE = 8'h30,
  parameter logic [VEC_W-1:0] SPUR_VEC     = 8'h0F
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_start,
  input logic             done,
  input logic             dsack,
  input logic             avec,
  input logic             berr,
  input logic [VEC_W-1:0] vec_num,
  input logic [VEC_W:0]   vec_addr,
  input logic [LVL_W-1:0] ipl
);
  logic        ck_busy;
  logic [15:0] ck_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_busy <= 1'b0;
      ck_cnt  <= '0;
    end else if (ack_start && (!ck_busy || done)) begin
      ck_busy <= 1'b1;
      ck_cnt  <= '0;
    end else if (done) begin
      ck_busy <= 1'b0;
    end else if (ck_busy) begin
      ck_cnt <= ck_cnt + 16'd1;
    end
  end

  assert_one_resp_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({dsack, avec, berr}) == 1));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ({dsack, avec, berr} == 3'b000));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_addr_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (vec_addr == {vec_num, 1'b0}));
  assert_spur_R7: assert property (@(posedge clk) disable iff (rst)
    berr |-> (vec_num == SPUR_VEC));
  assert_timeout_R7: assert property (@(posedge clk) disable iff (rst)
    berr |-> (ck_cnt == 16'(TIMEOUT)));
  assert_auto_R5: assert property (@(posedge clk) disable iff (rst)
    avec |-> (vec_num == AUTOVEC_BASE + VEC_W'(ipl)));
endmodule

bind iack_arbiter iack_arbiter_chk #(
  .LVL_W(LVL_W), .VEC_W(VEC_W), .TIMEOUT(TIMEOUT),
  .AUTOVEC_BASE(AUTOVEC_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk(clk), .rst(rst), .ack_start(ack_start), .done(done), .dsack(dsack),
  .avec(avec), .berr(berr), .vec_num(vec_num), .vec_addr(vec_addr), .ipl(ipl)
);

// File: tb/sim_iack_arbiter.sv
`timescale 1ns/1ps
module sim_iack_arbiter;
  localparam int N = 4;
  localparam int TMO = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ack_start = 1'b0;
  logic [2:0]   ack_level = '0;
  logic [N-1:0] src_req = '0;
  logic [N*3-1:0] src_level = '0;
  logic [N*4-1:0] src_arb = '0;
  logic [N*8-1:0] src_vec = '0;
  logic [N-1:0] src_auto = '0;
  logic         avec_pin = 1'b0;
  logic         done, dsack, avec, berr;
  logic [7:0]   vec_num;
  logic [8:0]   vec_addr;
  logic [2:0]   ipl;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  iack_arbiter u0 (
    .clk(clk), .rst(rst), .ack_start(ack_start), .ack_level(ack_level),
    .src_req(src_req), .src_level(src_level), .src_arb(src_arb),
    .src_vec(src_vec), .src_auto(src_auto), .avec_pin(avec_pin),
    .done(done), .dsack(dsack), .avec(avec), .berr(berr),
    .vec_num(vec_num), .vec_addr(vec_addr), .ipl(ipl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_srcs();
    src_req = '0; src_level = '0; src_arb = '0; src_vec = '0; src_auto = '0;
    avec_pin = 1'b0;
  endtask

  task automatic set_src(input int i, input logic [2:0] lv, input logic [3:0] ar,
                         input logic [7:0] vc, input logic au);
    src_req[i] = 1'b1;
    src_level[i*3 +: 3] = lv;
    src_arb[i*4 +: 4] = ar;
    src_vec[i*8 +: 8] = vc;
    src_auto[i] = au;
  endtask

  // Starts a cycle; returns cycles from the start edge to the edge that raises done.
  // If again > 0, a second start at level lv2 is pulsed 'again' cycles in.
  task automatic run_ack(input logic [2:0] lv, input int again,
                         input logic [2:0] lv2, output int lat);
    @(negedge clk);
    ack_start = 1'b1; ack_level = lv;
    @(negedge clk);
    ack_start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      if (again > 0 && lat == again) begin ack_start = 1'b1; ack_level = lv2; end
      else ack_start = 1'b0;
      @(negedge clk);
      lat++;
    end
    ack_start = 1'b0;
  endtask

  task automatic expect_resp(input string tag, input int lat, input int lat_exp,
                             input logic [2:0] flags, input int vec, input int lv);
    chk({tag, " latency"}, lat, lat_exp);
    chk({tag, " flags R10"}, {dsack, avec, berr}, flags);
    chk({tag, " vec_num"}, vec_num, vec);
    chk({tag, " vec_addr R8"}, vec_addr, vec * 2);
    chk({tag, " ipl R9"}, ipl, lv);
    @(negedge clk);
    chk({tag, " done pulse R10"}, {done, dsack, avec, berr}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 outputs", {done, dsack, avec, berr}, 0);
    chk("R1 vec_num", vec_num, 0);
    chk("R1 vec_addr", vec_addr, 0);
    chk("R1 ipl", ipl, 0);
  endtask

  task automatic t_single();
    int lat;
    clear_srcs();
    set_src(0, 3'd5, 4'd3, 8'h41, 1'b0);
    set_src(1, 3'd2, 4'd9, 8'h52, 1'b0);
    run_ack(3'd5, 0, 3'd0, lat);
    expect_resp("R2 R4 single", lat, 1, 3'b100, 8'h41, 5);
  endtask

  task automatic t_tie();
    int lat;
    clear_srcs();
    set_src(0, 3'd4, 4'd6, 8'h61, 1'b0);
    set_src(1, 3'd4, 4'd11, 8'h72, 1'b0);
    set_src(2, 3'd4, 4'd0, 8'h7F, 1'b0);
    set_src(3, 3'd3, 4'd15, 8'h33, 1'b0);
    run_ack(3'd4, 0, 3'd0, lat);
    expect_resp("R3 tie", lat, 1, 3'b100, 8'h72, 4);
  endtask

  task automatic t_auto();
    int lat;
    clear_srcs();
    set_src(2, 3'd6, 4'd5, 8'h99, 1'b1);
    set_src(0, 3'd6, 4'd2, 8'h11, 1'b0);
    run_ack(3'd6, 0, 3'd0, lat);
    expect_resp("R5 autovector", lat, 1, 3'b010, 8'h36, 6);
  endtask

  task automatic t_pin();
    int lat;
    clear_srcs();
    set_src(1, 3'd2, 4'd7, 8'h44, 1'b0);
    avec_pin = 1'b1;
    run_ack(3'd2, 0, 3'd0, lat);
    expect_resp("R6 pin", lat, 1, 3'b010, 8'h32, 2);
    avec_pin = 1'b0;
  endtask

  task automatic t_mismatch();
    int lat;
    clear_srcs();
    set_src(0, 3'd1, 4'd7, 8'h21, 1'b0);
    run_ack(3'd3, 0, 3'd0, lat);
    expect_resp("R2 R7 mismatch", lat, TMO, 3'b001, 8'h0F, 3);
  endtask

  task automatic t_zero_arb();
    int lat;
    clear_srcs();
    set_src(0, 3'd3, 4'd0, 8'h21, 1'b0);
    run_ack(3'd3, 0, 3'd0, lat);
    expect_resp("R2 R7 zero arb", lat, TMO, 3'b001, 8'h0F, 3);
  endtask

  task automatic t_no_req();
    int lat;
    clear_srcs();
    set_src(1, 3'd7, 4'd9, 8'h5A, 1'b0);
    src_req[1] = 1'b0;
    run_ack(3'd7, 0, 3'd0, lat);
    expect_resp("R2 R7 no request", lat, TMO, 3'b001, 8'h0F, 7);
  endtask

  task automatic t_restart();
    int lat;
    clear_srcs();
    set_src(3, 3'd6, 4'd1, 8'h66, 1'b0);
    run_ack(3'd3, 4, 3'd6, lat);
    expect_resp("R11 restart ignored", lat, TMO, 3'b001, 8'h0F, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_tie();
    t_auto();
    t_pin();
    t_mismatch();
    t_zero_arb();
    t_no_req();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule